// File: doc/BRIEF.md
# Online Logic Implication Checker Bank

This block is a concurrent error monitor. It watches a vector of internal node values, the probe vector, taken from the logic it protects. It checks a fixed set of logic implications against that vector. Each implication has the form "when node P equals value v, node Q must equal value w". An implication fails only when its antecedent node carries the stated value and its consequent node does not carry the implied value. A single implication catches every fault that breaks its relationship, whatever the fault site.

Each implication is a same-cycle check or a cross-cycle check. A same-cycle check takes both nodes from the same clock. A cross-cycle check keeps the probe vector of the previous enabled clock in a register, takes its antecedent from that register, and takes its consequent from the current probe. This lets the bank catch wrong values latched into flip-flops, including late-arriving data, without extra capture timing.

The implication list is fixed at build time through parameters. Each implication has an antecedent index and polarity, a consequent index and polarity, and a cross-cycle select bit. The outputs are a registered per-implication violation vector, a combined error pulse, and a sticky error flag that stays set until it is cleared.

Top module: `imp_check_bank`

## Requirements
- R1: After a synchronous reset, `viol_o`, `err_o` and `sticky_o` are all 0.
- R2: Same-cycle implication k sets `viol_o[k]` if and only if, in one enabled cycle, the probe bit at its antecedent index equals its antecedent polarity and the probe bit at its consequent index differs from its consequent polarity.
- R3: Cross-cycle implication k sets `viol_o[k]` if and only if the antecedent bit held its polarity in the previous enabled cycle and the consequent bit differs from its polarity in the current enabled cycle. The two enabled cycles must be consecutive.
- R4: In the first enabled cycle after reset, and in the first enabled cycle after `en_i` returns high, every cross-cycle bit of `viol_o` stays 0.
- R5: While `en_i` is low, the cycle produces an all-zero `viol_o`.
- R6: `viol_o` is registered. A probe value sampled at a rising edge shows up in `viol_o` right after that edge, and never before it.
- R7: `err_o` is 1 exactly when at least one bit of `viol_o` is 1, in the same cycle.
- R8: `sticky_o` goes to 1 together with any violation bit and stays 1 for as long as `clr_i` is low.
- R9: When `clr_i` is high in a cycle that also raises a violation, `sticky_o` stays at 1.
- R10: When `clr_i` is high in a cycle that raises no violation, `sticky_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Checking enable |
| probe_i | input | NODES | Monitored node values |
| clr_i | input | 1 | Clears the sticky flag |
| viol_o | output | NIMP | Registered violation bit for each implication |
| err_o | output | 1 | OR of all violation bits |
| sticky_o | output | 1 | Sticky error flag |

## Verification
The bench drives every ordered pair of probe values through the default four-implication bank. With each value it tests every same-cycle implication, and with each consecutive pair it tests every cross-cycle implication. A design that takes a cross-cycle antecedent from the current probe, or that uses a stale capture, reports wrong bits on many of these pairs. The bench drops the enable between sweep blocks. This catches a bank that flags cross-cycle errors against an antecedent captured before the pause, and a bank that reports anything while disabled. Clear pulses that land on cycles with and without a fresh violation expose a sticky flag that clears when it should hold. They also expose a flag that ignores the clear. A check made just before the edge catches a violation vector that is not registered.

// File: rtl/imp_chk_pkg.sv
package imp_chk_pkg;

    typedef enum logic {
        KIND_SAME  = 1'b0,
        KIND_CROSS = 1'b1
    } imp_kind_e;

    function automatic logic pol_match(input logic node_val, input logic pol);
        return node_val == pol;
    endfunction

endpackage

// File: rtl/imp_probe_reg.sv
module imp_probe_reg #(
    parameter int unsigned NODES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [NODES-1:0] probe_i,
    output logic [NODES-1:0] prev_o,
    output logic             prev_vld_o
);
    typedef struct packed {
        logic [NODES-1:0] prb;
        logic             vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (en_i) begin
            cap_d.prb = probe_i;
            cap_d.vld = 1'b1;
        end else begin
            cap_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign prev_o     = cap_q.prb;
    assign prev_vld_o = cap_q.vld;

    AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !prev_vld_o); // R4
endmodule

// File: rtl/imp_eval_unit.sv
module imp_eval_unit
    import imp_chk_pkg::*;
#(
    parameter int unsigned NODES = 4,
    parameter int unsigned ANT   = 0,
    parameter logic        A_POL = 1'b1,
    parameter int unsigned CON   = 1,
    parameter logic        C_POL = 1'b0,
    parameter imp_kind_e   KIND  = KIND_SAME
) (
    input  logic             en_i,
    input  logic [NODES-1:0] cur_i,
    input  logic [NODES-1:0] prev_i,
    input  logic             prev_vld_i,
    output logic             hit_o
);
    logic ant_ok;
    logic con_ok;
    logic armed;

    generate
        if (KIND == KIND_CROSS) begin : g_cross
            assign ant_ok = pol_match(prev_i[ANT], A_POL);
            assign armed  = prev_vld_i;
        end else begin : g_same
            assign ant_ok = pol_match(cur_i[ANT], A_POL);
            assign armed  = 1'b1;
        end
    endgenerate

    assign con_ok = pol_match(cur_i[CON], C_POL);
    assign hit_o  = en_i & armed & ant_ok & ~con_ok;
endmodule

// File: rtl/imp_err_collect.sv
module imp_err_collect #(
    parameter int unsigned NIMP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NIMP-1:0] hit_i,
    input  logic            clr_i,
    output logic [NIMP-1:0] viol_o,
    output logic            err_o,
    output logic            sticky_o
);
    typedef struct packed {
        logic [NIMP-1:0] viol;
        logic            err;
        logic            sticky;
    } res_t;

    res_t res_d, res_q;
    logic any_hit;

    always_comb begin
        any_hit       = |hit_i;
        res_d         = res_q;
        res_d.viol    = hit_i;
        res_d.err     = any_hit;
        res_d.sticky  = any_hit | (res_q.sticky & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign viol_o   = res_q.viol;
    assign err_o    = res_q.err;
    assign sticky_o = res_q.sticky;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        sticky_o && !clr_i |=> sticky_o); // R8
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (|hit_i) |=> sticky_o); // R8
    AST_CLR_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
        clr_i && (|hit_i) |=> sticky_o); // R9
    AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (rst)
        clr_i && !(|hit_i) |=> !sticky_o); // R10
endmodule

// File: rtl/imp_check_bank.sv
module imp_check_bank
    import imp_chk_pkg::*;
#(
    parameter int unsigned NODES = 4,
    parameter int unsigned NIMP  = 4,
    parameter int unsigned IDX_W = $clog2(NODES),
    parameter logic [NIMP*IDX_W-1:0] ANT_IDX = {2'd3, 2'd1, 2'd2, 2'd0},
    parameter logic [NIMP-1:0]       ANT_POL = 4'b1001,
    parameter logic [NIMP*IDX_W-1:0] CON_IDX = {2'd0, 2'd2, 2'd3, 2'd1},
    parameter logic [NIMP-1:0]       CON_POL = 4'b1000,
    parameter logic [NIMP-1:0]       XCYC    = 4'b1100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [NODES-1:0] probe_i,
    input  logic             clr_i,
    output logic [NIMP-1:0]  viol_o,
    output logic             err_o,
    output logic             sticky_o
);
    logic [NODES-1:0] prev;
    logic             prev_vld;
    logic [NIMP-1:0]  hit;

    imp_probe_reg #(.NODES(NODES)) i_cap (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .probe_i    (probe_i),
        .prev_o     (prev),
        .prev_vld_o (prev_vld)
    );

    for (genvar k = 0; k < NIMP; k++) begin : g_imp
        localparam int unsigned AI = int'(ANT_IDX[k*IDX_W +: IDX_W]);
        localparam int unsigned CI = int'(CON_IDX[k*IDX_W +: IDX_W]);
        localparam imp_kind_e   KD = XCYC[k] ? KIND_CROSS : KIND_SAME;

        imp_eval_unit #(
            .NODES (NODES),
            .ANT   (AI),
            .A_POL (ANT_POL[k]),
            .CON   (CI),
            .C_POL (CON_POL[k]),
            .KIND  (KD)
        ) i_unit (
            .en_i       (en_i),
            .cur_i      (probe_i),
            .prev_i     (prev),
            .prev_vld_i (prev_vld),
            .hit_o      (hit[k])
        );
    end

    imp_err_collect #(.NIMP(NIMP)) i_col (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit),
        .clr_i    (clr_i),
        .viol_o   (viol_o),
        .err_o    (err_o),
        .sticky_o (sticky_o)
    );

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> viol_o == '0); // R5
    AST_XC_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(en_i) |=> (viol_o & XCYC) == '0); // R4
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|viol_o) |-> err_o && sticky_o); // R7
endmodule

// File: tb/test_imp_check_bank.sv
`timescale 1ns/1ps
module test_imp_check_bank;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_i = 1'b0;
    logic [3:0] probe_i = '0;
    logic       clr_i = 1'b0;
    logic [3:0] viol_o;
    logic       err_o;
    logic       sticky_o;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic [3:0] m_prev = '0;
    logic       m_vld  = 1'b0;
    logic       m_sticky = 1'b0;

    always #4 clk = ~clk;

    imp_check_bank i_imp_check_bank (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .probe_i  (probe_i),
        .clr_i    (clr_i),
        .viol_o   (viol_o),
        .err_o    (err_o),
        .sticky_o (sticky_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] p, input logic e, input logic c);
        logic [3:0] ev;
        logic       first;
        probe_i = p;
        en_i    = e;
        clr_i   = c;
        ev      = '0;
        first   = e && !m_vld;
        if (e) begin
            ev[0] = p[0] & p[1];
            ev[1] = ~p[2] & p[3];
            ev[2] = m_vld & ~m_prev[1] & p[2];
            ev[3] = m_vld & m_prev[3] & ~p[0];
            m_prev = p;
        end
        m_vld    = e;
        m_sticky = (|ev) | (m_sticky & ~c);
        @(posedge clk);
        #1;
        if (!e) begin
            chk("R5 viol while disabled", viol_o, ev);
        end else begin
            chk("R2 same-cycle bits", {2'b00, viol_o[1:0]}, {2'b00, ev[1:0]});
            if (first) chk("R4 cross bits first enabled cycle", {2'b00, viol_o[3:2]}, 4'b0000);
            else       chk("R3 cross-cycle bits", {2'b00, viol_o[3:2]}, {2'b00, ev[3:2]});
        end
        chk("R7 err_o", {3'b000, err_o}, {3'b000, |ev});
        if (c && (|ev))  chk("R9 sticky on clear plus violation", {3'b000, sticky_o}, {3'b000, m_sticky});
        else if (c)      chk("R10 sticky clear", {3'b000, sticky_o}, {3'b000, m_sticky});
        else             chk("R8 sticky hold/set", {3'b000, sticky_o}, {3'b000, m_sticky});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset viol", viol_o, 4'b0000);
        chk("R1 reset err/sticky", {2'b00, err_o, sticky_o}, 4'b0000);
        rst = 1'b0;

        step(4'b0000, 1'b1, 1'b0);
        step(4'b0000, 1'b1, 1'b0);
        probe_i = 4'b0011;
        #1;
        chk("R6 no change before edge", viol_o, 4'b0000);
        step(4'b0011, 1'b1, 1'b0);
        step(4'b0000, 1'b1, 1'b1);

        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(a[3:0], 1'b1, ((a + b) % 5) == 0);
                step(b[3:0], 1'b1, ((a + 2 * b) % 7) == 0);
            end
            step(4'b1111, 1'b0, a[0]);
            step(4'b1011, 1'b0, 1'b0);
        end

        step(4'b1000, 1'b1, 1'b0);
        step(4'b0001, 1'b1, 1'b0);
        step(4'b0000, 1'b1, 1'b1);
        step(4'b0000, 1'b1, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule